// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by timing the clear pulses it sends. Once the power-up sequencer raises `run_en`, the timer restarts and runs a closed window followed by an open window. A falling edge on the clear input during the open window counts as a valid service. It restarts the timer and raises a one-cycle `good_service` strobe.

A falling edge during the closed window means the software cleared too early. Reaching the end of the open window with no edge means it cleared too late. In either case the block drives `wd_reset_n` low for a fixed number of cycles, raises a one-cycle `bad_event` strobe, and starts a fresh closed window when the pulse ends.

The clear input must already be synchronised to `clk`. All durations come from two parameters:

- `TWD_CYC` is the nominal watchdog time in clock cycles.
- `OWP_PCT` is the window tolerance in percent.

The closed window lasts `TWD_CYC - TWD_CYC*OWP_PCT/100` cycles. The open window lasts `2*TWD_CYC*OWP_PCT/100` cycles. The reset pulse lasts `TWD_CYC/40` cycles, with a minimum of one.

Top module: `win_watchdog`

## Requirements
- R1: While `rst_n` is low, `wd_reset_n` is 1 and `good_service` and `bad_event` are 0.
- R2: When `run_en` is 0 at a clock edge, the timer goes idle after that edge: `wd_reset_n` is 1, no strobe is raised, and clear edges are ignored. When `run_en` returns to 1, a fresh closed window starts.
- R3: The closed window lasts CLOSED_CYC = TWD_CYC - TWD_CYC*OWP_PCT/100 cycles after a restart. A clear edge seen during it starts a reset pulse at that edge.
- R4: The open window lasts OPEN_CYC = 2*TWD_CYC*OWP_PCT/100 cycles after the closed window. A clear edge seen during it gives a one-cycle `good_service` and no reset, and the timer restarts with a fresh closed window.
- R5: If no clear edge is seen by the last open-window cycle, a reset pulse starts at the next edge, CLOSED_CYC+OPEN_CYC edges after the restart.
- R6: `wd_reset_n` stays low for exactly PULSE_CYC = max(1, TWD_CYC/40) cycles per pulse.
- R7: After a pulse ends, a fresh closed window starts. With no clears, `wd_reset_n` becomes a square wave: low for PULSE_CYC cycles, high for CLOSED_CYC+OPEN_CYC cycles.
- R8: A clear is the falling edge of `clr_in` (1 at one edge, 0 at the next). A level held low is a single event, and a fall while idle is used up there.
- R9: Clear edges while `wd_reset_n` is low are ignored: they neither lengthen the pulse nor produce a strobe.
- R10: `bad_event` is high for exactly one cycle, the first cycle of each reset pulse. It is never high together with `good_service`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run permission from the power-up sequencer |
| clr_in | input | 1 | Synchronised software clear; the falling edge counts |
| wd_reset_n | output | 1 | Active-low watchdog reset pulse |
| good_service | output | 1 | One-cycle strobe for each accepted open-window clear |
| bad_event | output | 1 | One-cycle strobe at the start of each reset pulse |

## Verification
The main pattern sweeps a single clear edge across every cycle of both windows, each time from a fresh start. This separates an early clear (reset pulse) from a valid one (strobe only) at the exact window boundary on each side.

Runs with no clears measure the first timeout, the pulse width and the repeat period. Other runs distinguish:
- a clear held low from a fresh edge;
- an edge inside the pulse, which must not count;
- a timer restarted by a valid service, which must open a fresh closed window.

Dropping `run_en` in mid-window and in mid-pulse shows that the idle state hides all timer activity.

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int TWD_CYC = 400,
  parameter int OWP_PCT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic clr_in,
  output logic wd_reset_n,
  output logic good_service,
  output logic bad_event
);
  localparam int HALF_OPEN  = TWD_CYC * OWP_PCT / 100;
  localparam int CLOSED_CYC = TWD_CYC - HALF_OPEN;
  localparam int OPEN_CYC   = 2 * HALF_OPEN;
  localparam int PULSE_CYC  = (TWD_CYC / 40 > 0) ? TWD_CYC / 40 : 1;
  localparam int MAX_CYC    = (CLOSED_CYC > OPEN_CYC) ?
                              ((CLOSED_CYC > PULSE_CYC) ? CLOSED_CYC : PULSE_CYC) :
                              ((OPEN_CYC > PULSE_CYC) ? OPEN_CYC : PULSE_CYC);
  localparam int CW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] C_LAST = CW'(CLOSED_CYC - 1);
  localparam logic [CW-1:0] O_LAST = CW'(OPEN_CYC - 1);
  localparam logic [CW-1:0] P_LAST = CW'(PULSE_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_CLOSED, S_OPEN, S_PULSE} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          clr_q;
  logic          fall;
  logic          last;

  assign fall = clr_q & ~clr_in;
  assign last = cnt == ((phase == S_CLOSED) ? C_LAST :
                        (phase == S_OPEN)   ? O_LAST : P_LAST);
  assign wd_reset_n = (phase != S_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= S_IDLE;
      cnt          <= '0;
      clr_q        <= 1'b1;
      good_service <= 1'b0;
      bad_event    <= 1'b0;
    end else begin
      clr_q        <= clr_in;
      good_service <= 1'b0;
      bad_event    <= 1'b0;
      if (!run_en) begin
        phase <= S_IDLE;
        cnt   <= '0;
      end else begin
        case (phase)
          S_IDLE: begin
            phase <= S_CLOSED;
            cnt   <= '0;
          end
          S_CLOSED: begin
            if (fall) begin
              phase     <= S_PULSE;
              cnt       <= '0;
              bad_event <= 1'b1;
            end else if (last) begin
              phase <= S_OPEN;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_OPEN: begin
            if (fall) begin
              phase        <= S_CLOSED;
              cnt          <= '0;
              good_service <= 1'b1;
            end else if (last) begin
              phase     <= S_PULSE;
              cnt       <= '0;
              bad_event <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            if (last) begin
              phase <= S_CLOSED;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

module win_watchdog_chk #(
  parameter int PULSE_CYC = 1
) (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic clr_in,
  input logic wd_reset_n,
  input logic good_service,
  input logic bad_event
);
  int low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= 0;
    else        low_run <= wd_reset_n ? 0 : low_run + 1;
  end

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (wd_reset_n && !good_service && !bad_event));

  a_r4_good_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    good_service |-> (wd_reset_n && !$past(clr_in)));

  a_r4_fresh_closed: assert property (@(posedge clk) disable iff (!rst_n)
    good_service |=> (wd_reset_n && !good_service));

  a_r6_pulse_not_long: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_reset_n |-> (low_run < PULSE_CYC));

  a_r10_bad_marks_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_reset_n) |-> bad_event);

  a_r10_bad_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bad_event |-> (!wd_reset_n && !good_service));
endmodule

bind win_watchdog win_watchdog_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .clr_in(clr_in),
  .wd_reset_n(wd_reset_n), .good_service(good_service), .bad_event(bad_event)
);

// File: tb/sim_win_watchdog.sv
module sim_win_watchdog;
  localparam int PER  = 10;
  localparam int TWD  = 80;
  localparam int OWP  = 20;
  localparam int HALF = TWD * OWP / 100;
  localparam int CC   = TWD - HALF;
  localparam int OC   = 2 * HALF;
  localparam int PC   = (TWD / 40 > 0) ? TWD / 40 : 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic clr_in = 1'b1;
  logic wd_reset_n, good_service, bad_event;
  int total = 0;
  int bad = 0;

  always #(PER/2) clk = ~clk;

  win_watchdog #(.TWD_CYC(TWD), .OWP_PCT(OWP)) u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .clr_in(clr_in),
    .wd_reset_n(wd_reset_n), .good_service(good_service), .bad_event(bad_event)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start();
    @(negedge clk);
    run_en = 1'b0;
    clr_in = 1'b1;
    repeat (3) @(negedge clk);
    run_en = 1'b1;
  endtask

  task automatic wait_low(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (wd_reset_n && n < 1000);
  endtask

  task automatic low_width(output int w);
    w = 1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (wd_reset_n) break;
      w++;
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(PER * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int n, w, quiet;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 wd_reset_n", wd_reset_n, 1);
    chk("R1 strobes", good_service + bad_event, 0);
    rst_n = 1'b1;

    // R3/R4 sweep of one clear edge over every window cycle
    for (int k = 1; k <= CC + OC; k++) begin
      start();
      repeat (k) @(negedge clk);
      clr_in = 1'b0;
      @(negedge clk);
      if (k <= CC) begin
        chk($sformatf("R3 early clear k=%0d reset", k), wd_reset_n, 0);
        chk($sformatf("R10 early clear k=%0d bad_event", k), bad_event, 1);
        chk($sformatf("R3 early clear k=%0d no good", k), good_service, 0);
        clr_in = 1'b1;
        low_width(w);
        chk($sformatf("R6 width k=%0d", k), w, PC);
      end else begin
        chk($sformatf("R4 good clear k=%0d no reset", k), wd_reset_n, 1);
        chk($sformatf("R4 good clear k=%0d good_service", k), good_service, 1);
        chk($sformatf("R4 good clear k=%0d no bad", k), bad_event, 0);
        clr_in = 1'b1;
        if (k == CC + 1) begin
          wait_low(n);
          chk("R4 restart then R5 timeout", n, CC + OC);
        end
        if (k == CC + OC) begin
          @(negedge clk);
          chk("R4 strobe one cycle", good_service, 0);
          clr_in = 1'b0;
          @(negedge clk);
          chk("R4 fresh closed window rejects clear", wd_reset_n, 0);
          clr_in = 1'b1;
        end
      end
    end

    // R5/R7/R9/R10 timeouts with no clears; an edge inside the pulse
    start();
    wait_low(n);
    chk("R5 first timeout", n, CC + OC + 1);
    chk("R10 bad_event at pulse start", bad_event, 1);
    clr_in = 1'b0;
    @(negedge clk);
    chk("R10 bad_event one cycle", bad_event, 0);
    chk("R9 no good during pulse", good_service, 0);
    low_width(w);
    chk("R9 pulse width with clear edge", w + 1, PC);
    wait_low(n);
    chk("R7 high part of square wave", n, CC + OC);
    low_width(w);
    chk("R7 low part of square wave", w, PC);
    wait_low(n);
    chk("R7 second period", n, CC + OC);
    clr_in = 1'b1;

    // R8 level held low (fall while idle) is not a clear
    @(negedge clk);
    run_en = 1'b0;
    clr_in = 1'b1;
    repeat (2) @(negedge clk);
    clr_in = 1'b0;
    repeat (2) @(negedge clk);
    run_en = 1'b1;
    wait_low(n);
    chk("R8 held level gives timeout only", n, CC + OC + 1);
    clr_in = 1'b1;

    // R2 idle hides clears; run_en low ends a pulse
    start();
    repeat (10) @(negedge clk);
    run_en = 1'b0;
    quiet = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      clr_in = i[0];
      if (!wd_reset_n || good_service || bad_event) quiet++;
    end
    chk("R2 idle quiet", quiet, 0);
    start();
    wait_low(n);
    run_en = 1'b0;
    @(negedge clk);
    chk("R2 run_en low ends pulse", wd_reset_n, 1);
    run_en = 1'b1;
    wait_low(n);
    chk("R2 re-enable fresh timeout", n, CC + OC + 1);

    summary();
  end
endmodule